// File: doc/BRIEF.md
# RMII Receive Decoder (MAC Side)

This block sits on the MAC side of a reduced media-independent interface and runs entirely on the interface's reference clock. The link carries a single combined carrier/data-valid line together with a two-bit receive data bus. The block splits that line into a clean carrier sense and a separate data valid, and discards the idle 00 dibits that come before the preamble. From the first 01 dibit on, it packs dibits into bytes with the least significant dibit first. It works at both link rates: at 100 Mbit/s every reference clock carries a dibit, and at 10 Mbit/s each dibit is held for ten clocks and is sampled once within that window.

The interface has no collision pin, so the block derives collision from the local transmit enable and the recovered carrier, not from the raw combined line. The combined line toggles at the end of a frame, while buffered data is still draining, and a raw AND would report a collision that is not there. A receive error seen at any point in a frame stays flagged until data valid ends.

The byte output is a stream with no back-pressure. `rx_byte_valid` pulses high for exactly one clock per completed byte, and `rx_byte` holds that byte until the next pulse. The link cannot be stalled, so the consumer must take every pulse. Frame delimiting and the CRC check belong to the MAC logic that follows.

Top module: `rmii_rx_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `crs`, `rx_dv`, `rx_er`, `rx_byte_valid` and `col` are low.
- R2: The block samples the link once per sample slot, and every output register changes only on a sampling edge. With `speed_100`=1 every clock edge is a sampling edge. With `speed_100`=0 the sampling edges are the first edge after reset release and every tenth edge after that.
- R3: When idle, a sample with `crs_dv`=1 raises `crs` on that same edge.
- R4: While carrier is up and alignment has not yet happened, every dibit other than 01 is discarded. The first 01 dibit becomes dibit 0 of the first byte and raises `rx_dv`.
- R5: After alignment, every four sampled dibits produce one byte, assembled with the first dibit in bits [1:0] and the fourth in bits [7:6]. `rx_byte_valid` pulses for one clock on the edge that samples the fourth dibit.
- R6: During data, `crs` falls on the edge that samples `crs_dv`=0 on the first dibit of a nibble (dibit 0 or 2 of a byte). A low `crs_dv` on dibit 1 or 3 leaves `crs` high. Once `crs` has fallen it stays low for the rest of the frame.
- R7: `rx_dv` stays high through isolated low samples of `crs_dv`. It falls on the edge that samples `crs_dv`=0 for the second time in a row. That dibit is not data, and a partly filled byte is dropped.
- R8: `col` equals `tx_en` AND the recovered `crs`. It is never derived from `crs_dv`, so transmitting while `crs_dv` toggles after `crs` has fallen gives no collision.
- R9: `rx_er_in`=1 on any sample while carrier or data is active sets `rx_er`. `rx_er` stays set until the edge where `rx_dv` (or carrier, before alignment) falls, and it clears on that edge.
- R10: If `crs_dv` is sampled low before any 01 dibit arrives, `crs` drops on that edge, and no `rx_dv` and no byte follow.
- R11: At 10 Mbit/s, frames decode to the same bytes whatever the offset between the ten-clock dibit windows and the sampling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 = 100 Mbit/s, 0 = 10 Mbit/s |
| crs_dv | input | 1 | Combined carrier / data valid from the link |
| rxd | input | 2 | Receive dibit |
| rx_er_in | input | 1 | Receive error from the link |
| tx_en | input | 1 | Local transmit enable |
| crs | output | 1 | Recovered carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Latched frame error |
| rx_byte | output | 8 | Assembled byte |
| rx_byte_valid | output | 1 | One-clock strobe for `rx_byte` |
| col | output | 1 | Collision indication |

## Verification
Every registered result (`crs`, `rx_dv`, `rx_er`, `rx_byte`, `rx_byte_valid`) is due on the sampling edge that takes in the deciding dibit, so it becomes visible within the same clock period. `col` is combinational and follows `tx_en` in the same cycle. The bench advances a behavioural model on each rising edge, using the same edge count to find the 10 Mbit/s sampling edges. It compares all outputs at the falling edge, half a period after any change. It drives inputs three nanoseconds after the rising edge, so no comparison falls on an edge. Each frame's captured bytes are also checked against the byte list the stimulus was built from.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;

  localparam logic [1:0] DIBIT_ALIGN = 2'b01;
endpackage

// File: rtl/rmii_rx_tick.sv
// Sample-slot generator: every clock at the fast rate, one clock in DIV at the slow rate.
module rmii_rx_tick #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_100,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  generate
    if (DIV > 1) begin : g_div
      always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = speed_100 || (cnt == '0);
    end else begin : g_nodiv
      always_ff @(posedge clk) cnt <= '0;
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/rmii_rx_frame.sv
// Carrier / data-valid split, alignment hunt and byte packing.
module rmii_rx_frame
  import rmii_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              crs_dv,
  input  logic [1:0]        rxd,
  input  logic              rx_er_in,
  output logic              crs,
  output logic              rx_dv,
  output logic              rx_er,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_vld
);
  localparam int DPB   = BYTE_W / 2;
  localparam int IDX_W = (DPB > 1) ? $clog2(DPB) : 1;
  localparam int SHW   = BYTE_W - 2;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DPB - 1);

  rx_state_e        st;
  logic [IDX_W-1:0] idx;
  logic [SHW-1:0]   sh;
  logic             prev_low;
  logic             crs_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      sh       <= '0;
      prev_low <= 1'b0;
      crs_q    <= 1'b0;
      err_q    <= 1'b0;
      byte_q   <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (tick) begin
        unique case (st)
          ST_IDLE: begin
            if (crs_dv) begin
              st    <= ST_HUNT;
              crs_q <= 1'b1;
            end
          end
          ST_HUNT: begin
            if (!crs_dv) begin
              st    <= ST_IDLE;
              crs_q <= 1'b0;
              err_q <= 1'b0;
            end else begin
              if (rx_er_in) err_q <= 1'b1;
              if (rxd == DIBIT_ALIGN) begin
                st       <= ST_DATA;
                idx      <= IDX_W'(1);
                sh       <= {rxd, sh[SHW-1:2]};
                prev_low <= 1'b0;
              end
            end
          end
          ST_DATA: begin
            if (!crs_dv && prev_low) begin
              st    <= ST_IDLE;
              crs_q <= 1'b0;
              err_q <= 1'b0;
              idx   <= '0;
            end else begin
              if (rx_er_in) err_q <= 1'b1;
              if (!crs_dv && !idx[0]) crs_q <= 1'b0;
              prev_low <= !crs_dv;
              if (idx == IDX_LAST) begin
                byte_q   <= {rxd, sh};
                byte_vld <= 1'b1;
                idx      <= '0;
              end else begin
                idx <= idx + 1'b1;
              end
              sh <= {rxd, sh[SHW-1:2]};
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign crs   = crs_q;
  assign rx_dv = (st == ST_DATA);
  assign rx_er = err_q;
endmodule

// File: rtl/rmii_rx_decoder.sv
module rmii_rx_decoder #(
  parameter int SLOW_DIV = 10,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_100,
  input  logic              crs_dv,
  input  logic [1:0]        rxd,
  input  logic              rx_er_in,
  input  logic              tx_en,
  output logic              crs,
  output logic              rx_dv,
  output logic              rx_er,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_byte_valid,
  output logic              col
);
  logic tick;

  rmii_rx_tick #(.DIV(SLOW_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_100 (speed_100),
    .tick      (tick)
  );

  rmii_rx_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .crs_dv   (crs_dv),
    .rxd      (rxd),
    .rx_er_in (rx_er_in),
    .crs      (crs),
    .rx_dv    (rx_dv),
    .rx_er    (rx_er),
    .byte_q   (rx_byte),
    .byte_vld (rx_byte_valid)
  );

  // Collision from the recovered carrier only (R8).
  assign col = tx_en & crs;
endmodule

// File: rtl/rmii_rx_decoder_chk.sv
module rmii_rx_decoder_chk #(
  parameter int SLOW_DIV = 10,
  parameter int BYTE_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              speed_100,
  input logic              crs_dv,
  input logic [1:0]        rxd,
  input logic              rx_er_in,
  input logic              tx_en,
  input logic              crs,
  input logic              rx_dv,
  input logic              rx_er,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_byte_valid,
  input logic              col
);
  p_strobe_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_valid |-> rx_dv);

  p_slow_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_100 && rx_byte_valid) |=> !rx_byte_valid);

  p_dv_starts_with_carrier_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> crs);

  p_carrier_stays_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && !crs) |=> (!crs || !rx_dv));

  p_err_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && rx_dv) |=> (rx_er || !rx_dv));

  p_err_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_dv) |-> !rx_er);

  p_no_col_without_carrier_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && crs_dv && !crs) |-> !col);
endmodule

bind rmii_rx_decoder rmii_rx_decoder_chk #(.SLOW_DIV(SLOW_DIV), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/rmii_rx_decoder_test.sv
module rmii_rx_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_100 = 1'b1;
  logic       crs_dv = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic       rx_er_in = 1'b0;
  logic       tx_en = 1'b0;
  logic       crs, rx_dv, rx_er, rx_byte_valid, col;
  logic [7:0] rx_byte;

  always #5 clk = ~clk;

  rmii_rx_decoder uut (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .crs_dv(crs_dv),
    .rxd(rxd), .rx_er_in(rx_er_in), .tx_en(tx_en), .crs(crs), .rx_dv(rx_dv),
    .rx_er(rx_er), .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid), .col(col)
  );

  int checks = 0;
  int fails  = 0;
  int hold   = 1;
  bit model_on = 1'b0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // Behavioural reference model
  int st = 0, k = 0, n = 0, acc = 0, m_byte = 0;
  bit m_crs = 0, m_err = 0, m_bv = 0, prevlow = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      st = 0; k = 0; n = 0; acc = 0; m_byte = 0;
      m_crs = 0; m_err = 0; m_bv = 0; prevlow = 0;
    end else begin
      m_bv = 0;
      if (speed_100 || (k % 10 == 0)) begin
        if (st == 0) begin
          if (crs_dv) begin st = 1; m_crs = 1; end
        end else if (st == 1) begin
          if (!crs_dv) begin st = 0; m_crs = 0; m_err = 0; end
          else begin
            if (rx_er_in) m_err = 1;
            if (rxd == 2'b01) begin st = 2; acc = 1; n = 1; prevlow = 0; end
          end
        end else begin
          if (!crs_dv && prevlow) begin st = 0; m_crs = 0; m_err = 0; end
          else begin
            if (rx_er_in) m_err = 1;
            if (!crs_dv && (n % 2 == 0)) m_crs = 0;
            acc = acc | (int'(rxd) << (2 * n));
            prevlow = !crs_dv;
            n++;
            if (n == 4) begin m_bv = 1; m_byte = acc; acc = 0; n = 0; end
          end
        end
      end
      k++;
    end
  end

  // Per-cycle comparison at the falling edge
  byte unsigned got[$];
  always @(negedge clk) begin
    if (model_on) begin
      chk(crs === m_crs, "R3/R6 crs", crs, m_crs);
      chk(rx_dv === (st == 2), "R4/R7 rx_dv", rx_dv, st == 2);
      chk(rx_er === m_err, "R9 rx_er", rx_er, m_err);
      chk(col === (tx_en & m_crs), "R8 col", col, tx_en & m_crs);
      chk(rx_byte_valid === m_bv, "R2/R5 strobe", rx_byte_valid, m_bv);
      if (m_bv) chk(rx_byte === m_byte[7:0], "R5 byte", rx_byte, m_byte);
    end
    if (rx_byte_valid === 1'b1) got.push_back(rx_byte);
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(bit c, bit [1:0] d, bit e, bit t);
    crs_dv = c; rxd = d; rx_er_in = e; tx_en = t;
    repeat (hold) @(posedge clk);
    #3;
  endtask

  byte unsigned pl[$];

  task automatic frame(int lead, bit tog, int er_b, int gl_b, int tx_b);
    for (int i = 0; i < lead; i++) send(1'b1, 2'b00, 1'b0, 1'b0);
    for (int i = 0; i < pl.size(); i++) begin
      for (int j = 0; j < 4; j++) begin
        bit c = 1'b1;
        if (tog && i == pl.size() - 1) c = j[0];
        if (i == gl_b && j == 1) c = 1'b0;
        send(c, pl[i][2*j +: 2], (i == er_b && j == 2), (tx_b >= 0 && i >= tx_b));
      end
    end
    send(1'b0, 2'b00, 1'b0, tx_b >= 0);
    send(1'b0, 2'b00, 1'b0, tx_b >= 0);
    for (int i = 0; i < 3; i++) send(1'b0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic check_bytes(string tag);
    chk(got.size() == pl.size(), tag, got.size(), pl.size());
    for (int i = 0; i < pl.size() && i < got.size(); i++)
      chk(got[i] == pl[i], tag, got[i], pl[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk({crs, rx_dv, rx_er, rx_byte_valid, col} === 5'b0, "R1 reset outputs",
        {crs, rx_dv, rx_er, rx_byte_valid, col}, 0);
    @(posedge clk); #3;
    rst_n = 1'b1;
    model_on = 1'b1;
    @(posedge clk); #3;

    // Fast frame, toggled end, transmit overlapping the tail (R4 R5 R6 R7 R8)
    pl = '{8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'hD5,
           8'h12, 8'hA7, 8'h3C, 8'hF0};
    got.delete();
    frame(5, 1'b1, -1, -1, 10);
    check_bytes("R4/R5 fast frame bytes");

    // Fast frame with error pulse and odd-position low (R6 R9)
    pl = '{8'h55, 8'h55, 8'hD5, 8'h81, 8'h7E, 8'h00};
    got.delete();
    frame(2, 1'b0, 3, 4, -1);
    check_bytes("R9 errored frame bytes");

    // False carrier (R10)
    got.delete();
    for (int i = 0; i < 4; i++) send(1'b1, 2'b00, 1'b0, 1'b0);
    send(1'b0, 2'b10, 1'b0, 1'b0);
    chk(crs === 1'b0 && rx_dv === 1'b0, "R10 false carrier drop", {crs, rx_dv}, 0);
    for (int i = 0; i < 3; i++) send(1'b0, 2'b00, 1'b0, 1'b0);
    chk(got.size() == 0, "R10 no bytes", got.size(), 0);

    // Slow rate with offset dibit windows (R2 R11)
    speed_100 = 1'b0;
    hold = 10;
    repeat (3) @(posedge clk);
    #3;
    pl = '{8'h55, 8'h55, 8'hD5, 8'h9B};
    got.delete();
    frame(3, 1'b1, -1, -1, 3);
    check_bytes("R11 slow frame bytes");

    repeat (7) @(posedge clk);
    #3;
    pl = '{8'h55, 8'hD5, 8'h4E};
    got.delete();
    frame(1, 1'b0, 2, -1, -1);
    check_bytes("R11 slow frame second phase");

    model_on = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule